// File: doc/BRIEF.md
# Predicated ALU Execute Unit

This block is the execute stage of a small 32-bit register-machine core. Each cycle it can accept one decoded operation. The operation carries an opcode, a sign bit, a destination register index and operand A. It also carries a source select for operand B, the three candidate B values (register, short immediate, long immediate) and a 3-bit condition mask. From these the block computes arithmetic, logic, shift, rotate, move and compare results. It drives the register file write port, and it tells fetch whether a trailing 32-bit immediate word was consumed.

The block holds three compare flags (greater, equal, less) and a predication-enable bit. While predication is enabled, an instruction whose condition mask shares no set bit with the stored flags is squashed. A squashed instruction writes nothing and changes no state. It still reports that its trailing immediate word must be skipped, so fetch stays aligned.

The input side is a valid/ready stream. An operation is taken on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` is low while reset is applied and high at all other times, so the unit never back-pressures. Upstream may hold `in_valid` high on every cycle. All results are registered and appear one cycle after acceptance. The flags and the enable bit update on the accepting edge, so a back-to-back operation is already predicated on them.

Top module: `pred_exec_unit`

## Requirements
- R1: Opcode 1 (add) writes A+B, or A-B when the sign bit is 1, both modulo 2^32.
- R2: Opcodes 2, 3, 4 write A&B, A|B and A^B. Opcode 5 writes the bitwise inverse of B. Opcode 14 (move) writes B.
- R3: Opcode 6 writes the low 32 bits of the product A*B.
- R4: Opcodes 7, 8 and 9 shift A by B: 7 is logical left, 8 is logical right, 9 is arithmetic right. An amount of 32 or more gives 0 for 7 and 8, and gives 32 copies of A's top bit for 9. Opcode 10 rotates A right by B modulo 32.
- R5: A shift or rotate (opcodes 7-10) whose B source is the long immediate (select 2) is illegal when not squashed. It pulses `illegal` and writes nothing. It leaves the flags and the enable bit unchanged.
- R6: Opcode 11 (compare) sets the flags from an unsigned comparison of A with B. The flags read {gt,eq,lt} on bits 2,1,0, and exactly one of them is set. B select 3 supplies zero, so A is compared against zero.
- R7: When the enable bit is 1 and cond_mask & flags is 0 (mask bits in the same order as the flags), the operation is squashed. `squash` pulses, nothing is written, and neither flags nor enable bit change.
- R8: Any accepted operation with B select 2 pulses `imm_consume`, whether it retires, is squashed or is illegal.
- R9: Opcode 13 sets all three flags to 1. Opcode 12 loads the enable bit from the sign bit. Both are subject to R7.
- R10: After reset the flags are 3'b111, the enable bit is 0, all pulse outputs are low and `in_ready` is high.
- R11: Each accepted operation produces exactly one of `retire`, `squash` or `illegal`, one cycle after acceptance. A cycle without acceptance produces none of them and no `imm_consume`.
- R12: `wr_en` rises only for retiring opcodes 1-10 and 14, and `wr_addr` then equals the accepted destination index. Two- and three-operand forms differ only in the destination index that decode supplies. Opcodes 0, 11, 12, 13 and 15 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented |
| in_ready | output | 1 | Unit accepts an operation (high except in reset) |
| in_op | input | 4 | Opcode |
| in_sign | input | 1 | Subtract select for add, value for set-enable |
| in_dst | input | REG_AW (4) | Destination register index |
| in_a | input | DATA_W (32) | Operand A |
| in_bsrc | input | 2 | B select: 0 register, 1 short imm, 2 long imm, 3 zero |
| in_breg | input | DATA_W (32) | Register value for B |
| in_imm_s | input | IMM_S_W (8) | Short immediate, zero-extended |
| in_imm_l | input | DATA_W (32) | Long immediate word that follows the opcode |
| in_cond | input | 3 | Condition mask {gt,eq,lt} |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | REG_AW (4) | Register file write index |
| wr_data | output | DATA_W (32) | Register file write data |
| retire | output | 1 | Previous accepted operation took effect |
| squash | output | 1 | Previous accepted operation was predicated off |
| illegal | output | 1 | Previous accepted operation was an illegal form |
| imm_consume | output | 1 | Fetch must skip the trailing immediate word |
| flags | output | 3 | Stored flags {gt,eq,lt} |
| pred_en | output | 1 | Stored predication-enable bit |

## Verification
The write port, the outcome pulses and `imm_consume` are due exactly one rising edge after acceptance. The flags and the enable bit are due on that same edge. The bench drives each operation on a falling edge. On the next falling edge it compares every output against a reference model that was advanced when that operation was driven, so each result is read in the single cycle where it belongs. Back-to-back operations expose that predication reads the state left by the previous operation and not an older value. Idle cycles are inserted to show that the pulses are quiet when nothing is accepted.

// File: rtl/pexu_pkg.sv
package pexu_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_AND  = 4'd2,
    OP_OR   = 4'd3,
    OP_XOR  = 4'd4,
    OP_NOT  = 4'd5,
    OP_MUL  = 4'd6,
    OP_LSL  = 4'd7,
    OP_LSR  = 4'd8,
    OP_ASR  = 4'd9,
    OP_ROR  = 4'd10,
    OP_CMP  = 4'd11,
    OP_SETP = 4'd12,
    OP_RSTF = 4'd13,
    OP_MOV  = 4'd14,
    OP_RSV  = 4'd15
  } op_e;

  typedef enum logic [1:0] {
    BSRC_REG  = 2'd0,
    BSRC_IMMS = 2'd1,
    BSRC_IMML = 2'd2,
    BSRC_ZERO = 2'd3
  } bsrc_e;

  localparam int NFLAGS = 3;

  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } flags_t;

  function automatic logic op_is_shift(op_e op);
    return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
  endfunction

  function automatic logic op_writes_reg(op_e op);
    case (op)
      OP_ADD, OP_AND, OP_OR, OP_XOR, OP_NOT, OP_MUL,
      OP_LSL, OP_LSR, OP_ASR, OP_ROR, OP_MOV: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pexu_bmux.sv
module pexu_bmux
  import pexu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IMM_S_W = 8
) (
  input  bsrc_e               sel,
  input  logic [DATA_W-1:0]   b_reg,
  input  logic [IMM_S_W-1:0]  b_imm_s,
  input  logic [DATA_W-1:0]   b_imm_l,
  output logic [DATA_W-1:0]   b_val,
  output logic                long_imm
);

  localparam int PAD_W = DATA_W - IMM_S_W;

  logic [DATA_W-1:0] imm_s_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign imm_s_ext = {{PAD_W{1'b0}}, b_imm_s};
    end else begin : g_nopad
      assign imm_s_ext = b_imm_s[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (sel)
      BSRC_REG:  b_val = b_reg;
      BSRC_IMMS: b_val = imm_s_ext;
      BSRC_IMML: b_val = b_imm_l;
      default:   b_val = '0;
    endcase
  end

  assign long_imm = (sel == BSRC_IMML);

endmodule

// File: rtl/pexu_alu.sv
module pexu_alu
  import pexu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  op_e               op,
  input  logic              sub,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result,
  output flags_t            cmp
);

  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]     amt;
  logic                amt_big;
  logic [2*DATA_W-1:0] dbl_rot;
  logic [DATA_W-1:0]   sh_l, sh_r, sh_a, rot;

  assign amt     = b[SH_W-1:0];
  assign amt_big = |b[DATA_W-1:SH_W];
  assign dbl_rot = {a, a} >> amt;

  assign sh_l = amt_big ? '0 : (a << amt);
  assign sh_r = amt_big ? '0 : (a >> amt);
  assign sh_a = amt_big ? {DATA_W{a[DATA_W-1]}} : DATA_W'($signed(a) >>> amt);
  assign rot  = dbl_rot[DATA_W-1:0];

  always_comb begin
    case (op)
      OP_ADD:  result = sub ? (a - b) : (a + b);
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_XOR:  result = a ^ b;
      OP_NOT:  result = ~b;
      OP_MUL:  result = a * b;
      OP_LSL:  result = sh_l;
      OP_LSR:  result = sh_r;
      OP_ASR:  result = sh_a;
      OP_ROR:  result = rot;
      OP_MOV:  result = b;
      default: result = '0;
    endcase
  end

  assign cmp.gt = (a > b);
  assign cmp.eq = (a == b);
  assign cmp.lt = (a < b);

endmodule

// File: rtl/pexu_pred.sv
module pexu_pred
  import pexu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  op_e               op,
  input  logic              sign,
  input  logic [NFLAGS-1:0] cond,
  input  flags_t            cmp,
  input  logic              illegal_now,
  output logic              squash_now,
  output flags_t            flags_q,
  output logic              pred_q
);

  logic take;

  assign squash_now = pred_q && ((cond & flags_q) == '0);
  assign take       = fire && !squash_now && !illegal_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '1;
      pred_q  <= 1'b0;
    end else if (take) begin
      case (op)
        OP_CMP:  flags_q <= cmp;
        OP_RSTF: flags_q <= '1;
        OP_SETP: pred_q  <= sign;
        default: ;
      endcase
    end
  end

  assert_rstf_sets_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_RSTF && !squash_now) |=> (flags_q == 3'b111));

  assert_cmp_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_CMP && !squash_now) |=> ($countones(flags_q) == 1));

  assert_squash_keeps_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && squash_now) |=> ($stable(flags_q) && $stable(pred_q)));

  assert_illegal_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && illegal_now) |=> ($stable(flags_q) && $stable(pred_q)));

endmodule

// File: rtl/pred_exec_unit.sv
module pred_exec_unit
  import pexu_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_AW  = 4,
  parameter int IMM_S_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [3:0]         in_op,
  input  logic               in_sign,
  input  logic [REG_AW-1:0]  in_dst,
  input  logic [DATA_W-1:0]  in_a,
  input  logic [1:0]         in_bsrc,
  input  logic [DATA_W-1:0]  in_breg,
  input  logic [IMM_S_W-1:0] in_imm_s,
  input  logic [DATA_W-1:0]  in_imm_l,
  input  logic [2:0]         in_cond,
  output logic               wr_en,
  output logic [REG_AW-1:0]  wr_addr,
  output logic [DATA_W-1:0]  wr_data,
  output logic               retire,
  output logic               squash,
  output logic               illegal,
  output logic               imm_consume,
  output logic [2:0]         flags,
  output logic               pred_en
);

  op_e               op;
  logic              fire;
  logic [DATA_W-1:0] b_val;
  logic              long_imm;
  logic [DATA_W-1:0] alu_res;
  flags_t            cmp;
  logic              squash_now;
  logic              illegal_now;
  logic              effect_now;
  flags_t            flags_q;
  logic              ready_q;

  assign op   = op_e'(in_op);
  assign fire = in_valid && in_ready;

  pexu_bmux #(.DATA_W(DATA_W), .IMM_S_W(IMM_S_W)) u_bmux (
    .sel      (bsrc_e'(in_bsrc)),
    .b_reg    (in_breg),
    .b_imm_s  (in_imm_s),
    .b_imm_l  (in_imm_l),
    .b_val    (b_val),
    .long_imm (long_imm)
  );

  pexu_alu #(.DATA_W(DATA_W)) u_alu (
    .op     (op),
    .sub    (in_sign),
    .a      (in_a),
    .b      (b_val),
    .result (alu_res),
    .cmp    (cmp)
  );

  assign illegal_now = !squash_now && op_is_shift(op) && long_imm;
  assign effect_now  = !squash_now && !illegal_now;

  pexu_pred u_pred (
    .clk         (clk),
    .rst_n       (rst_n),
    .fire        (fire),
    .op          (op),
    .sign        (in_sign),
    .cond        (in_cond),
    .cmp         (cmp),
    .illegal_now (illegal_now),
    .squash_now  (squash_now),
    .flags_q     (flags_q),
    .pred_q      (pred_en)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready_q     <= 1'b0;
      wr_en       <= 1'b0;
      wr_addr     <= '0;
      wr_data     <= '0;
      retire      <= 1'b0;
      squash      <= 1'b0;
      illegal     <= 1'b0;
      imm_consume <= 1'b0;
    end else begin
      ready_q     <= 1'b1;
      retire      <= fire && effect_now;
      squash      <= fire && squash_now;
      illegal     <= fire && illegal_now;
      imm_consume <= fire && long_imm;
      wr_en       <= fire && effect_now && op_writes_reg(op);
      if (fire) begin
        wr_addr <= in_dst;
        wr_data <= alu_res;
      end
    end
  end

  assign in_ready = ready_q;
  assign flags    = flags_q;

  assert_outcome_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retire, squash, illegal}));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid && in_ready) |-> !(retire || squash || illegal || imm_consume));

  assert_write_needs_retire_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> retire);

  assert_consume_has_outcome_R8: assert property (@(posedge clk) disable iff (!rst_n)
    imm_consume |-> (retire || squash || illegal));

endmodule

// File: tb/sim_pred_exec_unit.sv
module sim_pred_exec_unit;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [3:0]  in_op;
  logic        in_sign;
  logic [3:0]  in_dst;
  logic [31:0] in_a;
  logic [1:0]  in_bsrc;
  logic [31:0] in_breg;
  logic [7:0]  in_imm_s;
  logic [31:0] in_imm_l;
  logic [2:0]  in_cond;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [31:0] wr_data;
  logic        retire, squash, illegal, imm_consume;
  logic [2:0]  flags;
  logic        pred_en;

  pred_exec_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_sign(in_sign), .in_dst(in_dst), .in_a(in_a),
    .in_bsrc(in_bsrc), .in_breg(in_breg), .in_imm_s(in_imm_s),
    .in_imm_l(in_imm_l), .in_cond(in_cond), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .retire(retire),
    .squash(squash), .illegal(illegal), .imm_consume(imm_consume),
    .flags(flags), .pred_en(pred_en)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // reference model state and expected outputs
  logic [2:0]  m_flags;
  logic        m_pred;
  logic        e_wr_en, e_retire, e_squash, e_illegal, e_consume;
  logic [3:0]  e_wr_addr;
  logic [31:0] e_wr_data;
  string       e_tag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R10", "in_ready", 32'(in_ready), 32'd1);
    chk(e_tag, "retire", 32'(retire), 32'(e_retire));
    chk(e_tag, "squash", 32'(squash), 32'(e_squash));
    chk(e_tag, "illegal", 32'(illegal), 32'(e_illegal));
    chk(e_tag, "imm_consume", 32'(imm_consume), 32'(e_consume));
    chk(e_tag, "wr_en", 32'(wr_en), 32'(e_wr_en));
    chk(e_tag, "flags", 32'(flags), 32'(m_flags));
    chk(e_tag, "pred_en", 32'(pred_en), 32'(m_pred));
    if (e_wr_en) begin
      chk("R12", "wr_addr", 32'(wr_addr), 32'(e_wr_addr));
      chk(e_tag, "wr_data", wr_data, e_wr_data);
    end
  endtask

  function automatic string op_tag(int op);
    case (op)
      1: return "R1";
      2, 3, 4, 5, 14: return "R2";
      6: return "R3";
      7, 8, 9, 10: return "R4";
      11: return "R6";
      12, 13: return "R9";
      default: return "R12";
    endcase
  endfunction

  // behavioural result of a retiring operation
  function automatic logic [31:0] ref_result(int op, logic s, logic [31:0] a, logic [31:0] b);
    logic [63:0] p;
    logic [31:0] r;
    longint unsigned ua, ub;
    ua = a; ub = b;
    case (op)
      1: r = s ? 32'((ua + 64'h1_0000_0000 - ub) % 64'h1_0000_0000) : 32'((ua + ub) % 64'h1_0000_0000);
      2: r = a & b;
      3: r = a | b;
      4: r = a ^ b;
      5: r = ~b;
      14: r = b;
      6: begin p = ua * ub; r = p[31:0]; end
      7: begin
        r = a;
        if (b >= 32) r = 0; else for (int k = 0; k < int'(b); k++) r = {r[30:0], 1'b0};
      end
      8: begin
        r = a;
        if (b >= 32) r = 0; else for (int k = 0; k < int'(b); k++) r = {1'b0, r[31:1]};
      end
      9: begin
        r = a;
        for (int k = 0; k < ((b >= 32) ? 32 : int'(b)); k++) r = {r[31], r[31:1]};
      end
      10: begin
        r = a;
        for (int k = 0; k < int'(b % 32); k++) r = {r[0], r[31:1]};
      end
      default: r = 0;
    endcase
    return r;
  endfunction

  task automatic step(int op, logic s, logic [3:0] dst, logic [31:0] a, logic [1:0] bsrc,
                      logic [31:0] breg, logic [7:0] imms, logic [31:0] imml, logic [2:0] cond);
    logic [31:0] b;
    logic sq, il, sh;
    @(negedge clk);
    compare_all();
    in_valid = 1'b1; in_op = 4'(op); in_sign = s; in_dst = dst; in_a = a;
    in_bsrc = bsrc; in_breg = breg; in_imm_s = imms; in_imm_l = imml; in_cond = cond;
    case (bsrc)
      2'd0: b = breg;
      2'd1: b = {24'd0, imms};
      2'd2: b = imml;
      default: b = 0;
    endcase
    sh = (op >= 7 && op <= 10);
    sq = m_pred && ((cond & m_flags) == 3'b000);
    il = !sq && sh && (bsrc == 2'd2);
    e_consume = (bsrc == 2'd2);
    e_squash = sq; e_illegal = il; e_retire = !sq && !il;
    e_wr_en = e_retire && ((op >= 1 && op <= 10) || op == 14);
    e_wr_addr = dst;
    e_wr_data = ref_result(op, s, a, b);
    if (sq) e_tag = e_consume ? "R8" : "R7";
    else if (il) e_tag = "R5";
    else e_tag = op_tag(op);
    if (e_retire) begin
      if (op == 11) m_flags = {a > b, a == b, a < b};
      if (op == 13) m_flags = 3'b111;
      if (op == 12) m_pred = s;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    compare_all();
    in_valid = 1'b0;
    in_op = 4'($urandom_range(0, 15));
    in_bsrc = 2'd2;
    e_wr_en = 0; e_retire = 0; e_squash = 0; e_illegal = 0; e_consume = 0;
    e_tag = "R11";
  endtask

  function automatic logic [31:0] pick_amt();
    case ($urandom_range(0, 6))
      0: return 0;
      1: return 31;
      2: return 32;
      3: return 33;
      4: return 255;
      5: return $urandom_range(0, 31);
      default: return $urandom;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_op = 0; in_sign = 0; in_dst = 0; in_a = 0;
    in_bsrc = 0; in_breg = 0; in_imm_s = 0; in_imm_l = 0; in_cond = 0;
    m_flags = 3'b111; m_pred = 1'b0;
    e_wr_en = 0; e_retire = 0; e_squash = 0; e_illegal = 0; e_consume = 0; e_wr_addr = 0;
    e_wr_data = 0; e_tag = "R10";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: reset state is checked by the first compare in the first step
    // R1 add / subtract wrap
    step(1, 0, 4'd1, 32'd5, 2'd0, 32'd7, 0, 0, 3'b000);
    step(1, 1, 4'd2, 32'd3, 2'd1, 0, 8'd5, 0, 3'b000);
    step(1, 0, 4'd3, 32'hFFFF_FFFF, 2'd2, 0, 0, 32'd1, 3'b000);
    // R2 logic / move
    step(2, 0, 4'd4, 32'hF0F0_1234, 2'd0, 32'h0FF0_FFFF, 0, 0, 0);
    step(3, 0, 4'd5, 32'h0000_00F0, 2'd1, 0, 8'h0F, 0, 0);
    step(4, 0, 4'd6, 32'hAAAA_AAAA, 2'd2, 0, 0, 32'hFFFF_0000, 0);
    step(5, 0, 4'd7, 32'h0, 2'd0, 32'h1234_5678, 0, 0, 0);
    step(14, 0, 4'd8, 32'h0, 2'd2, 0, 0, 32'hDEAD_BEEF, 0);
    // R3 multiply
    step(6, 0, 4'd9, 32'h0001_0000, 2'd0, 32'h0001_0000, 0, 0, 0);
    step(6, 0, 4'd10, 32'hFFFF_FFFF, 2'd1, 0, 8'd3, 0, 0);
    // R4 shift boundaries
    step(7, 0, 4'd1, 32'h8000_0001, 2'd0, 32'd31, 0, 0, 0);
    step(7, 0, 4'd1, 32'hFFFF_FFFF, 2'd0, 32'd32, 0, 0, 0);
    step(8, 0, 4'd1, 32'hFFFF_FFFF, 2'd1, 0, 8'd33, 0, 0);
    step(9, 0, 4'd1, 32'h8000_0000, 2'd0, 32'd40, 0, 0, 0);
    step(9, 0, 4'd1, 32'h8000_0000, 2'd1, 0, 8'd4, 0, 0);
    step(10, 0, 4'd1, 32'h0000_00F1, 2'd0, 32'd36, 0, 0, 0);
    step(10, 0, 4'd1, 32'h1234_5678, 2'd1, 0, 8'd255, 0, 0);
    // R5 illegal long immediate shift, R8 consume
    step(7, 0, 4'd2, 32'h1, 2'd2, 0, 0, 32'd1, 0);
    // R6 compare forms
    step(11, 0, 0, 32'd9, 2'd0, 32'd3, 0, 0, 0);
    step(11, 0, 0, 32'd3, 2'd2, 0, 0, 32'd9, 0);
    step(11, 0, 0, 32'd0, 2'd3, 0, 0, 0, 0);
    // R9 / R7 / R8 predication
    step(12, 1, 0, 0, 2'd0, 0, 0, 0, 3'b000);
    step(1, 0, 4'd3, 32'd1, 2'd1, 0, 8'd1, 0, 3'b100);
    step(1, 0, 4'd3, 32'd1, 2'd2, 0, 0, 32'd1, 3'b001);
    step(13, 0, 0, 0, 2'd0, 0, 0, 0, 3'b100);
    step(1, 0, 4'd3, 32'd1, 2'd1, 0, 8'd1, 0, 3'b010);
    step(13, 0, 0, 0, 2'd0, 0, 0, 0, 3'b010);
    step(7, 0, 4'd3, 32'd1, 2'd2, 0, 0, 32'd1, 3'b100);
    idle();
    step(11, 0, 0, 32'd1, 2'd1, 0, 8'd2, 0, 3'b111);
    step(12, 0, 0, 0, 2'd0, 0, 0, 0, 3'b100);
    step(12, 0, 0, 0, 2'd0, 0, 0, 0, 3'b001);
    idle();
    idle();
    // mixed stream
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [1:0] bs;
      if ($urandom_range(0, 9) == 0) idle();
      op = $urandom_range(0, 15);
      bs = 2'($urandom_range(0, 3));
      step(op, 1'($urandom_range(0, 1)), 4'($urandom), $urandom, bs,
           (op >= 7 && op <= 10) ? pick_amt() : $urandom,
           8'($urandom), $urandom, 3'($urandom));
    end
    idle();
    idle();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule